// File: doc/BRIEF.md
# Address-Encoded Command Mailbox

This block watches the address, data and read/write lines of a 6502-family processor bus and turns selected accesses into commands and operands for an attached coprocessor. A write to a dedicated zero-page location pushes the written byte onto a small operand stack. A write to a second zero-page location loads the command register and raises an execute strobe. In addition, two whole 256-byte pages are decoded so that the low address byte is the value itself. Any access in the operand page pushes that byte, and any access in the command page issues it as a command. Program code can therefore deliver a constant with a single absolute-mode no-op in four bus cycles, without using a register.

The block only listens to the bus. Each bus cycle is recognised once, on the first system clock that samples the phase-2 clock high after it was low, so a long phase-2 high time still yields a single action. A runtime select input switches the two value-carrying pages between a primary pair and an alternate pair. The coprocessor reads the top of the stack and the entry count, and removes entries with a pop strobe.

Top module: `mbx_cmd_mailbox`

## Requirements
- R1: A write (bus_rnw=0) to address $003E pushes the data-bus byte onto the operand stack. A read of $003E changes nothing.
- R2: Any access, read or write, whose upper address byte equals the operand page pushes the low address byte. The operand page is $1E when map_alt=0. The data bus is ignored for this access.
- R3: A write to address $003F loads cmd_byte with the data-bus byte and pulses cmd_exec. A read of $003F leaves cmd_byte unchanged and gives no pulse.
- R4: Any access, read or write, whose upper address byte equals the command page loads cmd_byte with the low address byte and pulses cmd_exec. The command page is $1F when map_alt=0.
- R5: When map_alt=1, the operand page is $08 and the command page is $09, and accesses to $1Exx and $1Fxx do nothing. When map_alt=0, accesses to $08xx and $09xx do nothing. The zero-page addresses work in both maps.
- R6: cmd_exec is high for exactly one clock, in the clock after the first clock edge that samples phi2 high following a low sample. However long phi2 stays high, one bus cycle yields at most one push or one command.
- R7: The operand stack is last-in first-out and 8 entries deep. opnd_top shows the most recently pushed entry still held, and reads 0 when the stack is empty. opnd_count gives the number of entries. A pop removes the top entry. A pop on an empty stack is ignored. A push and a pop in the same clock replace the top entry and leave the count unchanged.
- R8: A push to a full stack without a simultaneous pop is dropped, leaving the count and top unchanged, and sets opnd_ovf. opnd_ovf then stays set until reset.
- R9: After reset, opnd_count, opnd_top, cmd_byte, cmd_exec and opnd_ovf are all 0.
- R10: While phi2 is low nothing is pushed or issued. Addresses outside the two zero-page locations and the two selected pages are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than phi2 |
| rst_n | input | 1 | Asynchronous active-low reset |
| phi2 | input | 1 | Processor phase-2 clock, sampled by clk |
| bus_addr | input | ADDR_W | Processor address bus |
| bus_data | input | 8 | Processor data bus (observed only) |
| bus_rnw | input | 1 | 1 = read cycle, 0 = write cycle |
| map_alt | input | 1 | 0 = pages $1E/$1F, 1 = pages $08/$09 |
| pop | input | 1 | Coprocessor removes the top stack entry |
| opnd_top | output | 8 | Top entry of the operand stack |
| opnd_count | output | CNT_W | Number of entries held |
| opnd_ovf | output | 1 | Sticky overflow flag |
| cmd_byte | output | 8 | Last command byte |
| cmd_exec | output | 1 | One-clock execute strobe |

## Verification
A bus action takes effect on the first clock edge that samples phi2 high. The stack count, top, command byte and execute strobe are all registered at that edge, so each of them is due one clock later. The bench drives every input on the falling clock edge and raises phi2 there. It reads cmd_exec on the next three falling edges, expecting a 1 on the first and 0 after, and reads the stack and command outputs only after phi2 has dropped. Pops, including one placed on the same edge as a push, are likewise checked on the falling edge after the clock edge that applies them.

// File: rtl/mbx_pkg.sv
package mbx_pkg;
   localparam int BYTE_W = 8;

   typedef enum logic [1:0] {
      ACT_NONE = 2'd0,
      ACT_PUSH = 2'd1,
      ACT_CMD  = 2'd2
   } mbx_act_e;

   typedef struct packed {
      mbx_act_e          act;
      logic [BYTE_W-1:0] val;
   } mbx_req_t;
endpackage

// File: rtl/mbx_cycle_qual.sv
module mbx_cycle_qual (
   input  logic clk,
   input  logic rst_n,
   input  logic phi2,
   output logic cyc_start
);
   logic phi2_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) phi2_q <= 1'b1;
      else        phi2_q <= phi2;
   end

   // first clock of a phase-2 high period
   assign cyc_start = phi2 & ~phi2_q;
endmodule

// File: rtl/mbx_decode.sv
module mbx_decode
   import mbx_pkg::*;
#(
   parameter int ADDR_W      = 16,
   parameter int OPND_ZP     = 'h003E,
   parameter int CMD_ZP      = 'h003F,
   parameter int OPND_PG     = 'h1E,
   parameter int CMD_PG      = 'h1F,
   parameter int ALT_OPND_PG = 'h08,
   parameter int ALT_CMD_PG  = 'h09,
   parameter bit ALT_MAP_EN  = 1'b1
) (
   input  logic              cyc_start,
   input  logic [ADDR_W-1:0] addr,
   input  logic [BYTE_W-1:0] data,
   input  logic              rnw,
   input  logic              map_alt,
   output mbx_req_t          req
);
   localparam int PG_W = ADDR_W - BYTE_W;

   logic [PG_W-1:0] opnd_pg_sel;
   logic [PG_W-1:0] cmd_pg_sel;
   logic            zp_opnd_hit;
   logic            zp_cmd_hit;
   logic            pg_opnd_hit;
   logic            pg_cmd_hit;

   generate
      if (ALT_MAP_EN) begin : g_two_maps
         assign opnd_pg_sel = map_alt ? PG_W'(ALT_OPND_PG) : PG_W'(OPND_PG);
         assign cmd_pg_sel  = map_alt ? PG_W'(ALT_CMD_PG)  : PG_W'(CMD_PG);
      end else begin : g_one_map
         logic unused_sel;
         assign unused_sel  = map_alt;
         assign opnd_pg_sel = PG_W'(OPND_PG);
         assign cmd_pg_sel  = PG_W'(CMD_PG);
      end
   endgenerate

   assign zp_opnd_hit = !rnw && (addr == ADDR_W'(OPND_ZP));
   assign zp_cmd_hit  = !rnw && (addr == ADDR_W'(CMD_ZP));
   assign pg_opnd_hit = (addr[ADDR_W-1:BYTE_W] == opnd_pg_sel);
   assign pg_cmd_hit  = (addr[ADDR_W-1:BYTE_W] == cmd_pg_sel);

   always_comb begin
      req.act = ACT_NONE;
      req.val = '0;
      if (cyc_start) begin
         if (zp_cmd_hit) begin
            req.act = ACT_CMD;
            req.val = data;
         end else if (pg_cmd_hit) begin
            req.act = ACT_CMD;
            req.val = addr[BYTE_W-1:0];
         end else if (zp_opnd_hit) begin
            req.act = ACT_PUSH;
            req.val = data;
         end else if (pg_opnd_hit) begin
            req.act = ACT_PUSH;
            req.val = addr[BYTE_W-1:0];
         end
      end
   end
endmodule

// File: rtl/mbx_stack.sv
module mbx_stack
   import mbx_pkg::*;
#(
   parameter  int DEPTH = 8,
   localparam int CNT_W = $clog2(DEPTH + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              push,
   input  logic [BYTE_W-1:0] push_val,
   input  logic              pop,
   output logic [BYTE_W-1:0] top,
   output logic [CNT_W-1:0]  count,
   output logic              ovf
);
   logic [DEPTH-1:0][BYTE_W-1:0] entries;
   logic                         full;
   logic                         do_pop;
   logic                         do_push;
   logic                         drop;
   logic [CNT_W-1:0]             wr_pos;

   assign full    = (count == CNT_W'(DEPTH));
   assign do_pop  = pop && (count != '0);
   assign do_push = push && (!full || do_pop);
   assign drop    = push && full && !do_pop;
   assign wr_pos  = do_pop ? count - 1'b1 : count;

   generate
      for (genvar i = 0; i < DEPTH; i++) begin : g_entry
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                                entries[i] <= '0;
            else if (do_push && wr_pos == CNT_W'(i))   entries[i] <= push_val;
         end
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         count <= '0;
         ovf   <= 1'b0;
      end else begin
         count <= count + CNT_W'(do_push) - CNT_W'(do_pop);
         if (drop) ovf <= 1'b1;
      end
   end

   always_comb begin
      top = '0;
      for (int k = 0; k < DEPTH; k++)
         if (count == CNT_W'(k + 1)) top = entries[k];
   end

   AST_COUNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
      int'(count) <= DEPTH);                                            // R7
   AST_PUSH_GROWS: assert property (@(posedge clk) disable iff (!rst_n)
      (push && !pop && int'(count) < DEPTH) |=> int'(count) == int'($past(count)) + 1); // R7
   AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
      (push && !pop && full) |=> (full && $stable(top) && ovf));        // R8
   AST_OVF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      ovf |=> ovf);                                                     // R8
endmodule

// File: rtl/mbx_cmd_reg.sv
module mbx_cmd_reg
   import mbx_pkg::*;
(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load,
   input  logic [BYTE_W-1:0] val,
   output logic [BYTE_W-1:0] cmd_byte,
   output logic              exec
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cmd_byte <= '0;
         exec     <= 1'b0;
      end else begin
         exec <= load;
         if (load) cmd_byte <= val;
      end
   end
endmodule

// File: rtl/mbx_cmd_mailbox.sv
module mbx_cmd_mailbox
   import mbx_pkg::*;
#(
   parameter  int ADDR_W      = 16,
   parameter  int DEPTH       = 8,
   parameter  int OPND_ZP     = 'h003E,
   parameter  int CMD_ZP      = 'h003F,
   parameter  int OPND_PG     = 'h1E,
   parameter  int CMD_PG      = 'h1F,
   parameter  int ALT_OPND_PG = 'h08,
   parameter  int ALT_CMD_PG  = 'h09,
   parameter  bit ALT_MAP_EN  = 1'b1,
   localparam int CNT_W       = $clog2(DEPTH + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              phi2,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [7:0]        bus_data,
   input  logic              bus_rnw,
   input  logic              map_alt,
   input  logic              pop,
   output logic [7:0]        opnd_top,
   output logic [CNT_W-1:0]  opnd_count,
   output logic              opnd_ovf,
   output logic [7:0]        cmd_byte,
   output logic              cmd_exec
);
   generate
      if (ADDR_W <= BYTE_W || ADDR_W > 24) begin : g_bad_addr
         $error("mbx_cmd_mailbox: ADDR_W out of range");
      end
      if (DEPTH < 2) begin : g_bad_depth
         $error("mbx_cmd_mailbox: DEPTH must be at least 2");
      end
      if (OPND_PG == CMD_PG || (ALT_MAP_EN && ALT_OPND_PG == ALT_CMD_PG)) begin : g_bad_pg
         $error("mbx_cmd_mailbox: operand and command pages must differ");
      end
      if (OPND_ZP == CMD_ZP) begin : g_bad_zp
         $error("mbx_cmd_mailbox: zero-page locations must differ");
      end
   endgenerate

   logic     cyc_start;
   mbx_req_t req;

   mbx_cycle_qual u_qual (
      .clk       (clk),
      .rst_n     (rst_n),
      .phi2      (phi2),
      .cyc_start (cyc_start)
   );

   mbx_decode #(
      .ADDR_W      (ADDR_W),
      .OPND_ZP     (OPND_ZP),
      .CMD_ZP      (CMD_ZP),
      .OPND_PG     (OPND_PG),
      .CMD_PG      (CMD_PG),
      .ALT_OPND_PG (ALT_OPND_PG),
      .ALT_CMD_PG  (ALT_CMD_PG),
      .ALT_MAP_EN  (ALT_MAP_EN)
   ) u_dec (
      .cyc_start (cyc_start),
      .addr      (bus_addr),
      .data      (bus_data),
      .rnw       (bus_rnw),
      .map_alt   (map_alt),
      .req       (req)
   );

   mbx_stack #(.DEPTH(DEPTH)) u_stack (
      .clk      (clk),
      .rst_n    (rst_n),
      .push     (req.act == ACT_PUSH),
      .push_val (req.val),
      .pop      (pop),
      .top      (opnd_top),
      .count    (opnd_count),
      .ovf      (opnd_ovf)
   );

   mbx_cmd_reg u_cmd (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (req.act == ACT_CMD),
      .val      (req.val),
      .cmd_byte (cmd_byte),
      .exec     (cmd_exec)
   );

   AST_EXEC_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_exec |=> !cmd_exec);                                          // R6
   AST_EXEC_NEEDS_PHI2: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_exec |-> $past(phi2));                                        // R6
   AST_IDLE_NO_PUSH: assert property (@(posedge clk) disable iff (!rst_n)
      (!phi2 && !pop) |=> $stable(opnd_count));                         // R10
   AST_IDLE_NO_CMD: assert property (@(posedge clk) disable iff (!rst_n)
      !phi2 |=> (!cmd_exec && $stable(cmd_byte)));                      // R10
endmodule

// File: tb/tb_mbx_cmd_mailbox.sv
`timescale 1ns/1ps
module tb_mbx_cmd_mailbox;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        phi2 = 1'b0;
   logic [15:0] bus_addr = 16'h0200;
   logic [7:0]  bus_data = 8'h00;
   logic        bus_rnw = 1'b1;
   logic        map_alt = 1'b0;
   logic        pop = 1'b0;
   logic [7:0]  opnd_top;
   logic [3:0]  opnd_count;
   logic        opnd_ovf;
   logic [7:0]  cmd_byte;
   logic        cmd_exec;

   int n_chk = 0;
   int n_err = 0;
   int cyc   = 0;
   int pulses;
   bit first;

   always #2.5 clk = ~clk;

   mbx_cmd_mailbox dut (
      .clk(clk), .rst_n(rst_n), .phi2(phi2), .bus_addr(bus_addr),
      .bus_data(bus_data), .bus_rnw(bus_rnw), .map_alt(map_alt), .pop(pop),
      .opnd_top(opnd_top), .opnd_count(opnd_count), .opnd_ovf(opnd_ovf),
      .cmd_byte(cmd_byte), .cmd_exec(cmd_exec)
   );

   always @(posedge clk) begin
      cyc++;
      if (cyc > 150000) begin
         n_err++;
         $display("FAIL watchdog: actual %0d expected below 150000 cycles", cyc);
         $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
         $finish;
      end
   end

   task automatic chk(input bit ok, input string tag, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_err++;
         $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
      end
   endtask

   // one bus cycle with phi2 high for three clocks; counts execute pulses
   task automatic bus_cycle(input logic [15:0] a, input logic [7:0] d, input logic rnw);
      @(negedge clk);
      bus_addr = a; bus_data = d; bus_rnw = rnw; phi2 = 1'b0;
      @(negedge clk);
      phi2 = 1'b1;
      @(negedge clk);
      first  = cmd_exec;
      pulses = int'(cmd_exec);
      repeat (2) begin
         @(negedge clk);
         pulses += int'(cmd_exec);
      end
      phi2 = 1'b0;
      @(negedge clk);
      bus_addr = 16'h0200;
   endtask

   task automatic pop_one();
      @(negedge clk); pop = 1'b1;
      @(negedge clk); pop = 1'b0;
   endtask

   initial begin
      logic [7:0] cmd_prev;
      int         cnt_prev;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R9 reset state
      chk(opnd_count == 0, "R9 count", opnd_count, 0);
      chk(opnd_top == 0,   "R9 top", opnd_top, 0);
      chk(cmd_byte == 0,   "R9 cmd", cmd_byte, 0);
      chk(cmd_exec == 0,   "R9 exec", cmd_exec, 0);
      chk(opnd_ovf == 0,   "R9 ovf", opnd_ovf, 0);

      // R1 zero-page operand write and read
      bus_cycle(16'h003E, 8'hA5, 1'b0);
      chk(opnd_count == 1, "R1 count", opnd_count, 1);
      chk(opnd_top == 8'hA5, "R1 top", opnd_top, 'hA5);
      chk(pulses == 0, "R1 no exec", pulses, 0);
      bus_cycle(16'h003E, 8'h77, 1'b1);
      chk(opnd_count == 1, "R1 read ignored", opnd_count, 1);
      pop_one();
      chk(opnd_count == 0, "R7 pop", opnd_count, 0);

      // R3 zero-page command write and read
      bus_cycle(16'h003F, 8'h3C, 1'b0);
      chk(cmd_byte == 8'h3C, "R3 cmd", cmd_byte, 'h3C);
      chk(first == 1'b1, "R6 exec one clock after edge", first, 1);
      chk(pulses == 1, "R6 single pulse", pulses, 1);
      bus_cycle(16'h003F, 8'h99, 1'b1);
      chk(cmd_byte == 8'h3C, "R3 read ignored", cmd_byte, 'h3C);
      chk(pulses == 0, "R3 read no exec", pulses, 0);

      // R10 phi2 low: command page address held, nothing happens
      @(negedge clk);
      bus_addr = 16'h1F12; bus_rnw = 1'b1; phi2 = 1'b0;
      pulses = 0;
      repeat (4) begin @(negedge clk); pulses += int'(cmd_exec); end
      chk(pulses == 0, "R10 phi2 low exec", pulses, 0);
      chk(cmd_byte == 8'h3C, "R10 phi2 low cmd", cmd_byte, 'h3C);
      bus_addr = 16'h0200;
      // R10 non-decoded write
      bus_cycle(16'h003D, 8'h44, 1'b0);
      chk(opnd_count == 0, "R10 other address", opnd_count, 0);

      // R2 operand page sweep, LIFO order checked in groups of 8 (R7)
      for (int g = 0; g < 32; g++) begin
         for (int k = 0; k < 8; k++) begin
            logic [7:0] v;
            v = 8'(g * 8 + k);
            bus_cycle({8'h1E, v}, ~v, v[0]);
            chk(opnd_count == k + 1, "R2 count", opnd_count, k + 1);
            chk(opnd_top == v, "R2 low byte pushed", opnd_top, v);
         end
         for (int k = 7; k >= 0; k--) begin
            chk(opnd_top == 8'(g * 8 + k), "R7 lifo order", opnd_top, g * 8 + k);
            pop_one();
         end
         chk(opnd_count == 0, "R7 drained", opnd_count, 0);
      end

      // R4 command page sweep
      for (int v = 0; v < 256; v++) begin
         bus_cycle({8'h1F, 8'(v)}, ~8'(v), 1'(v >> 1));
         chk(cmd_byte == 8'(v), "R4 cmd low byte", cmd_byte, v);
         chk(pulses == 1 && first, "R4 exec pulse", pulses, 1);
      end

      // R5 page decode over every upper byte in both maps
      for (int m = 0; m < 2; m++) begin
         map_alt = 1'(m);
         for (int hb = 0; hb < 256; hb++) begin
            int  op_pg, cm_pg;
            op_pg    = m ? 'h08 : 'h1E;
            cm_pg    = m ? 'h09 : 'h1F;
            cnt_prev = opnd_count;
            cmd_prev = cmd_byte;
            bus_cycle({8'(hb), 8'h5A}, 8'h11, 1'b1);
            if (hb == op_pg) begin
               chk(opnd_count == cnt_prev + 1 && opnd_top == 8'h5A, "R5 operand page", opnd_top, 'h5A);
               pop_one();
            end else begin
               chk(opnd_count == cnt_prev, "R5 no push", opnd_count, cnt_prev);
            end
            if (hb == cm_pg) begin
               chk(pulses == 1 && cmd_byte == 8'h5A, "R5 command page", cmd_byte, 'h5A);
               bus_cycle(16'h003F, 8'h00, 1'b0);
            end else begin
               chk(pulses == 0 && cmd_byte == cmd_prev, "R5 no command", pulses, 0);
            end
         end
      end
      // R5 zero page still active in alternate map
      map_alt = 1'b1;
      bus_cycle(16'h003E, 8'h42, 1'b0);
      chk(opnd_count == 1 && opnd_top == 8'h42, "R5 alt zero page", opnd_top, 'h42);
      pop_one();
      map_alt = 1'b0;

      // R8 overflow
      for (int k = 0; k < 8; k++) bus_cycle(16'h003E, 8'(8'h10 + k), 1'b0);
      chk(opnd_count == 8 && opnd_ovf == 0, "R8 full no ovf", opnd_ovf, 0);
      bus_cycle(16'h1EEE, 8'h00, 1'b1);
      chk(opnd_count == 8, "R8 drop count", opnd_count, 8);
      chk(opnd_top == 8'h17, "R8 drop top", opnd_top, 'h17);
      chk(opnd_ovf == 1, "R8 ovf set", opnd_ovf, 1);
      // R7 push and pop on the same edge while full
      @(negedge clk); bus_addr = 16'h1E99; bus_rnw = 1'b1; phi2 = 1'b0;
      @(negedge clk); phi2 = 1'b1; pop = 1'b1;
      @(negedge clk); pop = 1'b0;
      @(negedge clk); phi2 = 1'b0; bus_addr = 16'h0200;
      chk(opnd_count == 8, "R7 push+pop count", opnd_count, 8);
      chk(opnd_top == 8'h99, "R7 push+pop top", opnd_top, 'h99);
      pop_one();
      chk(opnd_count == 7 && opnd_top == 8'h16, "R7 pop after replace", opnd_top, 'h16);
      repeat (8) pop_one();
      chk(opnd_count == 0, "R7 pop on empty ignored", opnd_count, 0);
      chk(opnd_top == 0, "R7 empty top", opnd_top, 0);
      chk(opnd_ovf == 1, "R8 ovf sticky", opnd_ovf, 1);

      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
   end
endmodule